// File: doc/BRIEF.md
# Compartment-Aware Peripheral Access Filter

This block sits in front of a set of peripheral slots and decides, cycle by cycle, whether an incoming bus transaction may reach its target. Each transaction presents a slot index, the requester's compartment identifier (a 3-bit CID), a secure flag and a privileged flag. The filter looks up the configuration it holds for that slot and raises either a grant or a deny in the same cycle. After a deny it pulses an error flag for one cycle and records the offending slot index.

Configuration is held in registers behind a simple 32-bit write/read port. Each slot has a secure-only bit, a privileged-only bit and a compartment word. The compartment word selects one of three CID policies. With filtering off, any compartment may access the slot. With static ownership, one CID owns the slot, and CID 0 means that any compartment may access it. With shared use, a whitelist names the allowed compartments, and the requester must also hold the slot's semaphore. The semaphore block is separate and reports, for the slot being accessed, whether the semaphore is taken and which CID holds it. A read-only word reports the sizes the block was built with.

Top module: `periph_access_filter`

## Requirements
- R1: After reset every security bit, privilege bit and compartment word is zero and `err_flag` is low. With this reset state, any transaction to an existing slot is granted.
- R2: The secure-only bit of slot n is bit n%32 of the word at byte offset 0x10 + 4*(n/32). The privileged-only bit of slot n is bit n%32 of the word at 0x30 + 4*(n/32). Both words read back what was written.
- R3: A slot whose secure-only bit is 1 denies every transaction with `txn_secure` = 0, whatever the CID result. A secure transaction that passes the other checks is granted.
- R4: A slot whose privileged-only bit is 1 denies every transaction with `txn_priv` = 0.
- R5: The compartment word of slot n is at offset 0x100 + 8*n. Its fields are: bit 0 filter enable, bit 1 shared-mode enable, bits 6:4 owner CID, bits 23:16 whitelist, where bit 16+c stands for CID c. All other bits are not stored and read as zero.
- R6: When the filter-enable bit is 0, the CID check passes for every requester CID. This holds even when the shared-mode bit is 1.
- R7: With filter enable = 1 and shared mode = 0, an owner CID of 0 admits every requester. Any other owner CID admits only a requester with an equal CID.
- R8: With filter enable and shared mode both 1, the owner CID is ignored. The requester passes only if its whitelist bit is set, `sem_taken` is 1 and `sem_holder` equals the requester's CID.
- R9: `txn_grant` and `txn_deny` are combinational. While `txn_valid` is 1 exactly one of them is 1. While `txn_valid` is 0 both are 0.
- R10: In the cycle after a deny, `err_flag` is 1 and `err_idx` holds the denied index. After a cycle with no deny, `err_flag` is 0 and `err_idx` keeps its value.
- R11: Offset 0xFEC reads {region count[31:24], initiator count[23:16], slot count[15:0]}, which is 0x00100080 with default parameters. Writes to it change nothing.
- R12: Register writes to slots at or above the slot count are ignored, and reads of them return zero. A transaction whose index is at or above the slot count is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data at `reg_addr` |
| txn_valid | input | 1 | Transaction present |
| txn_idx | input | 8 | Target slot index |
| txn_cid | input | 3 | Requester compartment ID |
| txn_secure | input | 1 | Requester is secure |
| txn_priv | input | 1 | Requester is privileged |
| sem_taken | input | 1 | Semaphore of the target slot is held |
| sem_holder | input | 3 | CID holding that semaphore |
| txn_grant | output | 1 | Transaction allowed |
| txn_deny | output | 1 | Transaction rejected |
| err_flag | output | 1 | One-cycle pulse after a deny |
| err_idx | output | 8 | Index of the last denied transaction |

## Verification
Slots are configured with each CID policy, and requests are sent to them from matching, non-matching and CID-0 compartments. This separates owner-CID matching from the owner-0 wildcard and from the filter-off case. The shared-mode slot is tried with the semaphore held by the requester, held by another whitelisted CID, and free, and also with a requester that equals the ignored owner CID but is not whitelisted. Together these show that all three conditions are needed. Secure and privileged slots get requests that differ only in the attribute flag. Out-of-range indices, masked compartment fields and the size word show that writes are filtered and that reads of missing registers return zero.

// File: rtl/pfilt_pkg.sv
package pfilt_pkg;

    localparam int CID_W = 3;
    localparam int WL_W  = 1 << CID_W;

    localparam int SEC_BASE  = 'h010;
    localparam int PRIV_BASE = 'h030;
    localparam int CID_BASE  = 'h100;
    localparam int HW_ADDR   = 'hFEC;

    typedef struct packed {
        logic [WL_W-1:0]  wlist;
        logic [CID_W-1:0] owner;
        logic             shared;
        logic             filt_en;
    } cid_cfg_t;

    function automatic logic [31:0] cfg_to_word(cid_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[0]                 = c.filt_en;
        w[1]                 = c.shared;
        w[4 +: CID_W]        = c.owner;
        w[16 +: WL_W]        = c.wlist;
        return w;
    endfunction

    function automatic cid_cfg_t word_to_cfg(logic [31:0] w);
        cid_cfg_t c;
        c.filt_en = w[0];
        c.shared  = w[1];
        c.owner   = w[4 +: CID_W];
        c.wlist   = w[16 +: WL_W];
        return c;
    endfunction

    function automatic logic cid_pass(cid_cfg_t c, logic [CID_W-1:0] cid,
                                      logic taken, logic [CID_W-1:0] holder);
        if (c.filt_en && c.shared)
            return c.wlist[cid] && taken && (holder == cid);
        else if (!c.filt_en)
            return 1'b1;
        else
            return (c.owner == '0) || (c.owner == cid);
    endfunction

endpackage

// File: rtl/pfilt_regs.sv
module pfilt_regs
    import pfilt_pkg::*;
#(
    parameter int NUM_PERIPH = 128,
    parameter int NUM_INIT   = 16,
    parameter int NUM_REGION = 0,
    parameter int ADDR_W     = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NUM_PERIPH-1:0] sec_q,
    output logic [NUM_PERIPH-1:0] priv_q,
    output cid_cfg_t          cfg_q [NUM_PERIPH]
);
    localparam int NW = (NUM_PERIPH + 31) / 32;
    localparam logic [31:0] HW_WORD =
        {8'(NUM_REGION), 8'(NUM_INIT), 16'(NUM_PERIPH)};

    int  sec_w, priv_w, slot;
    logic sec_hit, priv_hit, cid_hit;

    always_comb begin
        sec_w    = (int'(addr) - SEC_BASE) >>> 2;
        priv_w   = (int'(addr) - PRIV_BASE) >>> 2;
        slot     = (int'(addr) - CID_BASE) >>> 3;
        sec_hit  = (int'(addr) >= SEC_BASE)  && (addr[1:0] == 2'b00) && (sec_w  < NW);
        priv_hit = (int'(addr) >= PRIV_BASE) && (addr[1:0] == 2'b00) && (priv_w < NW);
        cid_hit  = (int'(addr) >= CID_BASE)  && (addr[2:0] == 3'b000) && (slot < NUM_PERIPH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q  <= '0;
            priv_q <= '0;
            for (int n = 0; n < NUM_PERIPH; n++) cfg_q[n] <= '0;
        end else if (we) begin
            for (int b = 0; b < 32; b++) begin
                if (sec_hit && (sec_w * 32 + b < NUM_PERIPH))
                    sec_q[sec_w * 32 + b] <= wdata[b];
                if (priv_hit && (priv_w * 32 + b < NUM_PERIPH))
                    priv_q[priv_w * 32 + b] <= wdata[b];
            end
            for (int n = 0; n < NUM_PERIPH; n++)
                if (cid_hit && slot == n) cfg_q[n] <= word_to_cfg(wdata);
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(addr) == HW_ADDR) rdata = HW_WORD;
        for (int b = 0; b < 32; b++) begin
            if (sec_hit && (sec_w * 32 + b < NUM_PERIPH))
                rdata[b] = sec_q[sec_w * 32 + b];
            if (priv_hit && (priv_w * 32 + b < NUM_PERIPH))
                rdata[b] = priv_q[priv_w * 32 + b];
        end
        for (int n = 0; n < NUM_PERIPH; n++)
            if (cid_hit && slot == n) rdata = cfg_to_word(cfg_q[n]);
    end

endmodule

// File: rtl/pfilt_decide.sv
module pfilt_decide
    import pfilt_pkg::*;
#(
    parameter int NUM_PERIPH = 128,
    parameter int IDX_W      = 8
) (
    input  logic                  txn_valid,
    input  logic [IDX_W-1:0]      txn_idx,
    input  logic [CID_W-1:0]      txn_cid,
    input  logic                  txn_secure,
    input  logic                  txn_priv,
    input  logic                  sem_taken,
    input  logic [CID_W-1:0]      sem_holder,
    input  logic [NUM_PERIPH-1:0] sec_q,
    input  logic [NUM_PERIPH-1:0] priv_q,
    input  cid_cfg_t              cfg_q [NUM_PERIPH],
    output logic                  grant,
    output logic                  deny
);
    cid_cfg_t sel_cfg;
    logic     sel_sec, sel_priv, present, ok;

    always_comb begin
        sel_cfg  = '0;
        sel_sec  = 1'b0;
        sel_priv = 1'b0;
        present  = 1'b0;
        for (int n = 0; n < NUM_PERIPH; n++) begin
            if ({1'b0, txn_idx} == (IDX_W+1)'(n)) begin
                sel_cfg  = cfg_q[n];
                sel_sec  = sec_q[n];
                sel_priv = priv_q[n];
                present  = 1'b1;
            end
        end
        ok = present
           && (!sel_sec  || txn_secure)
           && (!sel_priv || txn_priv)
           && cid_pass(sel_cfg, txn_cid, sem_taken, sem_holder);
        grant = txn_valid && ok;
        deny  = txn_valid && !ok;
    end

endmodule

// File: rtl/pfilt_errcap.sv
module pfilt_errcap #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             deny,
    input  logic [IDX_W-1:0] idx,
    output logic             err_flag,
    output logic [IDX_W-1:0] err_idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag <= 1'b0;
            err_idx  <= '0;
        end else begin
            err_flag <= deny;
            if (deny) err_idx <= idx;
        end
    end
endmodule

// File: rtl/periph_access_filter.sv
module periph_access_filter
    import pfilt_pkg::*;
#(
    parameter int NUM_PERIPH = 128,
    parameter int NUM_INIT   = 16,
    parameter int NUM_REGION = 0,
    parameter int IDX_W      = 8,
    parameter int ADDR_W     = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              txn_valid,
    input  logic [IDX_W-1:0]  txn_idx,
    input  logic [CID_W-1:0]  txn_cid,
    input  logic              txn_secure,
    input  logic              txn_priv,
    input  logic              sem_taken,
    input  logic [CID_W-1:0]  sem_holder,
    output logic              txn_grant,
    output logic              txn_deny,
    output logic              err_flag,
    output logic [IDX_W-1:0]  err_idx
);
    logic [NUM_PERIPH-1:0] sec_bits;
    logic [NUM_PERIPH-1:0] priv_bits;
    cid_cfg_t              cfg_bank [NUM_PERIPH];

    pfilt_regs #(
        .NUM_PERIPH(NUM_PERIPH), .NUM_INIT(NUM_INIT),
        .NUM_REGION(NUM_REGION), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .sec_q(sec_bits), .priv_q(priv_bits), .cfg_q(cfg_bank)
    );

    pfilt_decide #(.NUM_PERIPH(NUM_PERIPH), .IDX_W(IDX_W)) u_decide (
        .txn_valid(txn_valid), .txn_idx(txn_idx), .txn_cid(txn_cid),
        .txn_secure(txn_secure), .txn_priv(txn_priv),
        .sem_taken(sem_taken), .sem_holder(sem_holder),
        .sec_q(sec_bits), .priv_q(priv_bits), .cfg_q(cfg_bank),
        .grant(txn_grant), .deny(txn_deny)
    );

    pfilt_errcap #(.IDX_W(IDX_W)) u_err (
        .clk(clk), .rst(rst), .deny(txn_deny), .idx(txn_idx),
        .err_flag(err_flag), .err_idx(err_idx)
    );

endmodule

// File: rtl/pfilt_checker.sv
module pfilt_checker #(
    parameter int NUM_PERIPH = 128,
    parameter int IDX_W      = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  txn_valid,
    input logic [IDX_W-1:0]      txn_idx,
    input logic                  txn_secure,
    input logic                  txn_priv,
    input logic                  txn_grant,
    input logic                  txn_deny,
    input logic                  err_flag,
    input logic [IDX_W-1:0]      err_idx,
    input logic [NUM_PERIPH-1:0] sec_bits,
    input logic [NUM_PERIPH-1:0] priv_bits
);
    localparam int SPAN = 1 << IDX_W;
    logic [SPAN-1:0] sec_pad, priv_pad;
    assign sec_pad  = SPAN'(sec_bits);
    assign priv_pad = SPAN'(priv_bits);

    assert_one_verdict_R9: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> $onehot({txn_grant, txn_deny}));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !txn_valid |-> !(txn_grant || txn_deny));

    assert_secure_block_R3: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !txn_secure && sec_pad[txn_idx]) |-> !txn_grant);

    assert_priv_block_R4: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !txn_priv && priv_pad[txn_idx]) |-> !txn_grant);

    assert_err_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        txn_deny |=> (err_flag && err_idx == $past(txn_idx)));

    assert_err_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !txn_deny |=> (!err_flag && $stable(err_idx)));

endmodule

bind periph_access_filter pfilt_checker #(
    .NUM_PERIPH(NUM_PERIPH), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/sim_periph_access_filter.sv
module sim_periph_access_filter;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic [7:0] idx;
        logic [2:0] cid;
        logic       sec;
        logic       prv;
        logic       busy;
        logic [2:0] owner;
        logic       exp_grant;
        logic [3:0] req;
    } vec_t;

    // fields: idx, cid, sec, prv, sem_taken, sem_holder, expected grant, requirement
    localparam vec_t VEC [18] = '{
        '{8'd3,   3'd7, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 4'd6},   // R6 filter off
        '{8'd5,   3'd6, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 4'd7},   // R7 owner 0 wildcard
        '{8'd6,   3'd2, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 4'd7},   // R7 owner match
        '{8'd6,   3'd1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd7},   // R7 owner mismatch
        '{8'd6,   3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd7},   // R7 requester 0 not wildcard
        '{8'd40,  3'd3, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 4'd3},   // R3 secure passes
        '{8'd40,  3'd3, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd3},   // R3 non-secure blocked
        '{8'd40,  3'd1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 4'd7},   // R7 secure but wrong cid
        '{8'd70,  3'd0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1, 4'd4},   // R4 privileged passes
        '{8'd70,  3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd4},   // R4 unprivileged blocked
        '{8'd9,   3'd1, 1'b0, 1'b0, 1'b1, 3'd1, 1'b1, 4'd8},   // R8 holder is requester
        '{8'd9,   3'd1, 1'b0, 1'b0, 1'b1, 3'd4, 1'b0, 4'd8},   // R8 other holder
        '{8'd9,   3'd1, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 4'd8},   // R8 semaphore free
        '{8'd9,   3'd2, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 4'd8},   // R8 owner cid ignored
        '{8'd9,   3'd4, 1'b0, 1'b0, 1'b1, 3'd4, 1'b1, 4'd8},   // R8 second whitelisted
        '{8'd10,  3'd3, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 4'd6},   // R6 shared bit alone
        '{8'd200, 3'd0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 4'd12},  // R12 absent slot
        '{8'd127, 3'd5, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 4'd2}    // R2 last slot
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        txn_valid;
    logic [7:0]  txn_idx;
    logic [2:0]  txn_cid;
    logic        txn_secure, txn_priv, sem_taken;
    logic [2:0]  sem_holder;
    logic        txn_grant, txn_deny, err_flag;
    logic [7:0]  err_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    periph_access_filter u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .txn_valid(txn_valid), .txn_idx(txn_idx), .txn_cid(txn_cid),
        .txn_secure(txn_secure), .txn_priv(txn_priv),
        .sem_taken(sem_taken), .sem_holder(sem_holder),
        .txn_grant(txn_grant), .txn_deny(txn_deny),
        .err_flag(err_flag), .err_idx(err_idx)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(string req, logic [11:0] a, logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        txn_valid = 1'b0; txn_idx = '0; txn_cid = '0;
        txn_secure = 1'b0; txn_priv = 1'b0; sem_taken = 1'b0; sem_holder = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 err_flag", 32'(err_flag), 32'd0);
        rd_check("R1 cid word", 12'h130, 32'h0);
        rd_check("R1 sec word", 12'h014, 32'h0);
        @(negedge clk);
        txn_valid = 1'b1; txn_idx = 8'd6; txn_cid = 3'd1;
        #1;
        check("R1 grant", 32'({txn_grant, txn_deny}), 32'b10);
        txn_valid = 1'b0;
        // R9: idle gives no verdict
        #1;
        check("R9 idle", 32'({txn_grant, txn_deny}), 32'b00);

        // configuration
        wr(12'h128, 32'h0000_0001);          // slot 5: filter, owner 0
        wr(12'h130, 32'h0000_0021);          // slot 6: filter, owner 2
        wr(12'h148, 32'hFF12_00AF);          // slot 9: shared, owner 2, wl {1,4}, junk
        wr(12'h150, 32'h0000_0052);          // slot 10: shared bit only, owner 5
        wr(12'h240, 32'h0000_0031);          // slot 40: filter, owner 3
        wr(12'h014, 32'h0000_0100);          // slot 40 secure-only
        wr(12'h038, 32'h0000_0040);          // slot 70 privileged-only

        // R2 / R5: read back
        rd_check("R2 sec word1", 12'h014, 32'h0000_0100);
        rd_check("R2 priv word2", 12'h038, 32'h0000_0040);
        rd_check("R5 masked fields", 12'h148, 32'h0012_0023);

        // vector walk
        for (int i = 0; i < 18; i++) begin
            @(negedge clk);
            txn_valid = 1'b1; txn_idx = VEC[i].idx; txn_cid = VEC[i].cid;
            txn_secure = VEC[i].sec; txn_priv = VEC[i].prv;
            sem_taken = VEC[i].busy; sem_holder = VEC[i].owner;
            #1;
            checks++;
            if ({txn_grant, txn_deny} !== {VEC[i].exp_grant, !VEC[i].exp_grant}) begin
                fails++;
                $display("FAIL R%0d vec %0d actual=%b%b expected=%b%b", VEC[i].req, i,
                         txn_grant, txn_deny, VEC[i].exp_grant, !VEC[i].exp_grant);
            end
            @(posedge clk);
            #1;
            // R10: error pulse after deny, index captured
            check("R10 err_flag", 32'(err_flag), 32'(!VEC[i].exp_grant));
            if (!VEC[i].exp_grant) check("R10 err_idx", 32'(err_idx), 32'(VEC[i].idx));
        end
        // R10: index held through the following grant
        check("R10 err_idx held", 32'(err_idx), 32'd200);
        @(negedge clk);
        txn_valid = 1'b0;

        // R11: hardware configuration word, read-only
        rd_check("R11 hw word", 12'hFEC, 32'h0010_0080);
        wr(12'hFEC, 32'hFFFF_FFFF);
        rd_check("R11 hw word after write", 12'hFEC, 32'h0010_0080);

        // R12: writes beyond the slot count are dropped
        wr(12'h500, 32'h0000_0001);
        rd_check("R12 slot 128 read", 12'h500, 32'h0);
        rd_check("R12 slot 0 untouched", 12'h100, 32'h0);
        wr(12'h020, 32'hFFFF_FFFF);
        rd_check("R12 sec word4", 12'h020, 32'h0);
        rd_check("R12 priv word0 untouched", 12'h030, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule